// File: doc/BRIEF.md
# Stereo Soft Mute Ramp with Silence Monitor

This block sits in the sample path of a stereo audio converter, ahead of interpolation. On each sample strobe it takes a signed 24-bit left and right sample, scales both by a shared gain, and registers the result. A mute request makes the gain walk down in equal steps to zero. Releasing the request makes it walk back up to unity. The number of strobes a full walk takes depends on a two-bit speed selection, so the ramp lasts the same time whatever the sample rate.

A mute request dropped part way down does not restart the ramp. The gain turns around at its current value and climbs back at the same rate per strobe. A speed change made part way through a ramp keeps the direction and changes only the step.

A separate monitor counts consecutive strobes on which both channels carry exactly zero. It raises a flag after a long run of them and drops the flag on the first strobe that carries any non-zero data. A power-down input keeps the flag low and restarts the run.

Top module: `audio_softmute_zd`

## Requirements
- R1: While reset is active, and after it is released, both outputs are zero, the zero flag is low and the gain stands at unity (4096 of 4096).
- R2: On each strobe both outputs register floor(sample × g / 4096), computed in signed arithmetic. Here g is the gain before that strobe's own step. At unity gain each output equals its input.
- R3: While mute is requested, each strobe lowers the gain by a step. The gain stops at zero. The step is 4 for speed code 00, 2 for code 01, and 1 for codes 10 and 11. From unity with a full-scale input, the first zero output therefore appears on strobe 1025, 2049 or 4097.
- R4: While mute is not requested, each strobe raises the gain by the same step and stops at unity. From zero, the first output equal to the input appears on strobe 1025, 2049 or 4097.
- R5: Dropping mute part way down turns the gain around from its current value. After 100 muting strobes at code 00, the output equals the input again on the 101st strobe after release.
- R6: A speed change during a ramp keeps the direction and uses the new step from the next strobe. After 100 muting strobes at code 00 and a switch to code 10, the first zero output comes on the 3697th strobe.
- R7: The zero flag rises on the strobe that completes 8192 consecutive strobes with both channels exactly zero. It is still low after 8191 such strobes.
- R8: The zero flag falls on the first strobe in which either channel is non-zero, and the run count restarts from that strobe.
- R9: While power-down is high, the zero flag is low and the run count is cleared, whether or not a strobe is present.
- R10: Without a strobe, the outputs and the gain do not change, whatever the sample inputs and the mute request do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down indication, holds zero flag low |
| smp_stb | input | 1 | One-cycle sample strobe |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| mute_req | input | 1 | Mute request, high ramps down |
| speed_sel | input | 2 | Speed code: 00 normal, 01 double, 10/11 quad |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| zero_flag | output | 1 | Long run of silence on both channels |

## Verification
The bench measures ramp lengths strobe by strobe with full-scale positive and negative inputs. A step that is off by one, a wrong step for some speed code, or a gain applied one strobe late changes the count it reads. It cancels a mute part way down and switches speed part way through a ramp. A design that restarted the ramp, or one that latched the speed only at the start, would reach the target on the wrong strobe. The zero run is stopped one strobe short of its threshold, broken by data on a single channel, and cleared by power-down. These expose an off-by-one threshold, a monitor that watches only one channel, and a counter that power-down fails to clear. Inputs and the mute request are also toggled between strobes, which shows up any state that moves without a strobe.

// File: rtl/asmz_pkg.sv
package asmz_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_QUAD_B = 2'b11
  } spd_e;

  // Gain step per strobe; ramp length in strobes is full scale / step
  function automatic logic [2:0] ramp_step(spd_e s);
    case (s)
      SPD_NORMAL: return 3'd4;
      SPD_DOUBLE: return 3'd2;
      default:    return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/asmz_gain_ramp.sv
module asmz_gain_ramp #(
  parameter int GAIN_MAX = 4096,
  parameter int GAIN_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              mute,
  input  logic [1:0]        speed,
  output logic [GAIN_W-1:0] gain
);
  import asmz_pkg::*;

  localparam logic [GAIN_W-1:0] GMAX = GAIN_W'(GAIN_MAX);

  logic [GAIN_W-1:0] gain_q, gain_d, step;

  assign step = GAIN_W'(ramp_step(spd_e'(speed)));

  always_comb begin
    gain_d = gain_q;
    if (stb) begin
      if (mute) begin
        gain_d = (gain_q > step) ? gain_q - step : '0;
      end else begin
        gain_d = ((GMAX - gain_q) > step) ? gain_q + step : GMAX;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= GMAX;
    else        gain_q <= gain_d;
  end

  assign gain = gain_q;

endmodule

// File: rtl/asmz_scaler.sv
module asmz_scaler #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 13,
  parameter int SHIFT    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic [SAMPLE_W-1:0] din,
  input  logic [GAIN_W-1:0]   gain,
  output logic [SAMPLE_W-1:0] dout
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic [SAMPLE_W-1:0]      dout_q, dout_d;

  // Gain is non-negative: widen with a zero sign bit before the signed multiply
  assign prod = $signed(din) * $signed({1'b0, gain});

  always_comb begin
    dout_d = dout_q;
    if (stb) dout_d = SAMPLE_W'(prod >>> SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

endmodule

// File: rtl/asmz_zero_mon.sv
module asmz_zero_mon #(
  parameter int SAMPLE_W = 24,
  parameter int ZERO_RUN = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic                pd,
  input  logic [SAMPLE_W-1:0] din_l,
  input  logic [SAMPLE_W-1:0] din_r,
  output logic                flag
);
  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ZERO_RUN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             all_zero;

  assign all_zero = ~(|din_l) & ~(|din_r);

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (pd) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (stb) begin
      if (all_zero) cnt_d = (cnt_q == LIMIT) ? LIMIT : cnt_q + 1'b1;
      else          cnt_d = '0;
      flag_d = all_zero && (cnt_q >= LIMIT - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/audio_softmute_zd.sv
module audio_softmute_zd #(
  parameter int SAMPLE_W  = 24,
  parameter int BASE_RAMP = 1024,
  parameter int ZERO_RUN  = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_down,
  input  logic                smp_stb,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                mute_req,
  input  logic [1:0]          speed_sel,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                zero_flag
);
  // Slowest mode uses step 1, so full scale is four normal-mode ramps
  localparam int GAIN_MAX = BASE_RAMP * 4;
  localparam int SHIFT    = $clog2(GAIN_MAX);
  localparam int GAIN_W   = SHIFT + 1;
  localparam int NCH      = 2;

  logic [1:0]              rst_pipe;
  logic                    core_rst_n;
  logic [GAIN_W-1:0]       ramp_gain;
  logic [NCH-1:0][SAMPLE_W-1:0] din_bus, dout_bus;

  // Reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  asmz_gain_ramp #(.GAIN_MAX(GAIN_MAX), .GAIN_W(GAIN_W)) u_ramp (
    .clk   (clk),
    .rst_n (core_rst_n),
    .stb   (smp_stb),
    .mute  (mute_req),
    .speed (speed_sel),
    .gain  (ramp_gain)
  );

  assign din_bus = {in_right, in_left};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    asmz_scaler #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .SHIFT(SHIFT)) u_scale (
      .clk   (clk),
      .rst_n (core_rst_n),
      .stb   (smp_stb),
      .din   (din_bus[c]),
      .gain  (ramp_gain),
      .dout  (dout_bus[c])
    );
  end

  assign out_left  = dout_bus[0];
  assign out_right = dout_bus[1];

  asmz_zero_mon #(.SAMPLE_W(SAMPLE_W), .ZERO_RUN(ZERO_RUN)) u_zero (
    .clk   (clk),
    .rst_n (core_rst_n),
    .stb   (smp_stb),
    .pd    (pwr_down),
    .din_l (in_left),
    .din_r (in_right),
    .flag  (zero_flag)
  );

endmodule

// File: rtl/asmz_checker.sv
module asmz_checker #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 13,
  parameter int GAIN_MAX = 4096
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_down,
  input logic                smp_stb,
  input logic                mute_req,
  input logic [SAMPLE_W-1:0] in_left,
  input logic [SAMPLE_W-1:0] in_right,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic                zero_flag,
  input logic [GAIN_W-1:0]   gain
);

  a_r1_gain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= GAIN_W'(GAIN_MAX));

  a_r2_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && gain == GAIN_W'(GAIN_MAX) |=>
      out_left == $past(in_left) && out_right == $past(in_right));

  a_r3_mute_falls: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && mute_req && gain != '0 |=> gain < $past(gain));

  a_r4_release_rises: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && !mute_req && gain != GAIN_W'(GAIN_MAX) |=> gain > $past(gain));

  a_r7_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_flag) |-> $past(smp_stb) && $past(in_left) == '0 && $past(in_right) == '0);

  a_r8_drop_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && (in_left != '0 || in_right != '0) |=> !zero_flag);

  a_r9_pd_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !zero_flag);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(out_left) && $stable(out_right) && $stable(gain));

endmodule

bind audio_softmute_zd asmz_checker #(
  .SAMPLE_W (SAMPLE_W),
  .GAIN_W   (GAIN_W),
  .GAIN_MAX (GAIN_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .pwr_down  (pwr_down),
  .smp_stb   (smp_stb),
  .mute_req  (mute_req),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_left  (out_left),
  .out_right (out_right),
  .zero_flag (zero_flag),
  .gain      (ramp_gain)
);

// File: tb/audio_softmute_zd_test.sv
module audio_softmute_zd_test;

  logic        clk = 1'b0;
  logic        rst_n, pwr_down, smp_stb, mute_req;
  logic [23:0] in_left, in_right;
  logic [1:0]  speed_sel;
  logic [23:0] out_left, out_right;
  logic        zero_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state derived from the requirements
  int ref_gain;
  int ref_run;
  bit ref_flag;

  always #10 clk = ~clk;

  audio_softmute_zd uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .smp_stb   (smp_stb),
    .in_left   (in_left),
    .in_right  (in_right),
    .mute_req  (mute_req),
    .speed_sel (speed_sel),
    .out_left  (out_left),
    .out_right (out_right),
    .zero_flag (zero_flag)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] scale(logic [23:0] x, int g);
    longint p;
    p = longint'($signed(x)) * longint'(g);
    return 24'(p >>> 12);
  endfunction

  function automatic int step_of(logic [1:0] s);
    case (s)
      2'b00:   return 4;
      2'b01:   return 2;
      default: return 1;
    endcase
  endfunction

  // One strobe; outputs compared one clock later at the falling edge
  task automatic do_stb(logic [23:0] l, logic [23:0] r, string tag);
    logic [23:0] el, er;
    int st;
    @(negedge clk);
    in_left = l; in_right = r; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    el = scale(l, ref_gain);
    er = scale(r, ref_gain);
    st = step_of(speed_sel);
    if (mute_req) ref_gain = (ref_gain > st) ? ref_gain - st : 0;
    else          ref_gain = (4096 - ref_gain > st) ? ref_gain + st : 4096;
    if (l == 0 && r == 0) begin
      ref_flag = (ref_run >= 8191);
      ref_run  = (ref_run >= 8192) ? 8192 : ref_run + 1;
    end else begin
      ref_run = 0; ref_flag = 0;
    end
    chk({tag, " left"},  out_left,  el);
    chk({tag, " right"}, out_right, er);
    chk({tag, " flag"},  zero_flag, ref_flag);
  endtask

  task automatic ramp_len(string tag, bit want_zero, int expect_n);
    int n = 0;
    bit hit = 0;
    while (!hit && n < 5000) begin
      do_stb(24'h7FFFFF, 24'h800000, tag);
      n++;
      hit = want_zero ? (out_left == 0 && out_right == 0)
                      : (out_left == 24'h7FFFFF && out_right == 24'h800000);
    end
    chk({tag, " ramp length"}, n, expect_n);
  endtask

  task automatic pd_pulse(string tag);
    @(negedge clk); pwr_down = 1'b1;
    @(negedge clk); pwr_down = 1'b0;
    ref_run = 0; ref_flag = 0;
    chk({tag, " flag after power-down"}, zero_flag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pwr_down = 1'b0; smp_stb = 1'b0; mute_req = 1'b0;
    in_left = '0; in_right = '0; speed_sel = 2'b00;
    ref_gain = 4096; ref_run = 0; ref_flag = 0;
    repeat (3) @(negedge clk);
    chk("R1 left in reset", out_left, 0);
    chk("R1 flag in reset", zero_flag, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 right after reset", out_right, 0);
    chk("R1 flag after reset", zero_flag, 0);
    do_stb(24'h123456, 24'hFEDCBA, "R1 unity gain");

    // R2: pass-through at unity, varied data
    for (int i = 0; i < 20; i++) do_stb(24'($urandom), 24'($urandom), "R2");

    // R3 / R4 at each speed code
    mute_req = 1; speed_sel = 2'b00; ramp_len("R3 normal down", 1, 1025);
    mute_req = 0;                    ramp_len("R4 normal up", 0, 1025);
    mute_req = 1; speed_sel = 2'b01; ramp_len("R3 double down", 1, 2049);
    mute_req = 0;                    ramp_len("R4 double up", 0, 2049);
    mute_req = 1; speed_sel = 2'b10; ramp_len("R3 quad down", 1, 4097);
    mute_req = 0;                    ramp_len("R4 quad up", 0, 4097);
    mute_req = 1; speed_sel = 2'b11; ramp_len("R3 code11 down", 1, 4097);
    mute_req = 0; speed_sel = 2'b00; ramp_len("R4 normal up again", 0, 1025);

    // R5: cancel part way down
    mute_req = 1;
    for (int i = 0; i < 100; i++) do_stb(24'h7FFFFF, 24'h800000, "R5 partial");
    mute_req = 0; ramp_len("R5 reversal", 0, 101);

    // R6: speed change part way down
    mute_req = 1;
    for (int i = 0; i < 100; i++) do_stb(24'h7FFFFF, 24'h800000, "R6 partial");
    speed_sel = 2'b10; ramp_len("R6 rescaled", 1, 3697);
    mute_req = 0; speed_sel = 2'b00; ramp_len("R6 restore", 0, 1025);

    // R10: nothing moves without a strobe
    do_stb(24'h00ABCD, 24'h765432, "R10 setup");
    @(negedge clk);
    mute_req = 1; in_left = 24'h111111; in_right = 24'h800000;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 left held", out_left, 24'h00ABCD);
      chk("R10 right held", out_right, 24'h765432);
    end
    mute_req = 0;
    do_stb(24'h400000, 24'hC00000, "R10 gain unchanged");

    // R7: threshold of the zero run
    for (int i = 0; i < 8191; i++) do_stb(24'h0, 24'h0, "R7 run");
    chk("R7 low at 8191", zero_flag, 0);
    do_stb(24'h0, 24'h0, "R7 run");
    chk("R7 high at 8192", zero_flag, 1);
    do_stb(24'h0, 24'h0, "R7 saturate");

    // R8: one channel non-zero breaks the run
    do_stb(24'h0, 24'h000001, "R8 right data");
    chk("R8 dropped", zero_flag, 0);
    for (int i = 0; i < 3; i++) do_stb(24'h0, 24'h0, "R8 restart");

    // R9: power-down clears the flag and the run
    for (int i = 0; i < 8192; i++) do_stb(24'h0, 24'h0, "R9 run");
    chk("R9 flag high before", zero_flag, 1);
    pd_pulse("R9");
    do_stb(24'h0, 24'h0, "R9 restarted");
    chk("R9 still low", zero_flag, 0);

    // Mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [23:0] l, r;
      int sel;
      if ($urandom_range(63) == 0) mute_req = ~mute_req;
      if ($urandom_range(127) == 0) speed_sel = 2'($urandom);
      if ($urandom_range(255) == 0) pd_pulse("R9 random");
      sel = $urandom_range(7);
      case (sel)
        0, 1:    begin l = 0; r = 0; end
        2:       begin l = 24'h800000; r = 24'h7FFFFF; end
        default: begin l = 24'($urandom); r = 24'($urandom); end
      endcase
      do_stb(l, r, "R2 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule